// File: doc/BRIEF.md
# Serial Receive Framer with Status Flags

This block is the receive half of an asynchronous serial port. It watches a single serial input line and times each bit from a shared oversample tick. It takes three samples near the middle of every bit and uses a majority vote to decide the bit value. It recognises 8-bit and 9-bit frames, either of which may carry an even or odd parity bit. Each completed character is placed in an 8-bit data register. In 9-bit mode a separate ninth-bit output also holds a value.

A status byte reports whether a character is waiting and whether there was a parity, framing, noise or overrun problem. The host clears these flags with a fixed two-step access: it reads the status byte and then reads the data. Two interrupt requests are produced from the flags, each through its own enable. The enables are one for the ready flag and one for each error flag.

The tick generator and any character buffering sit outside this block. The line input passes through a synchronizer before use.

Top module: `serial_rx_framer`

## Requirements
- R1: After a high-to-low transition on the synchronized line, the receiver starts a start bit. If the majority of the three mid-bit samples of that start bit is high, the receiver returns to idle and no character is produced.
- R2: Each bit is sampled at oversample counts OVERSAMPLE/2-1, OVERSAMPLE/2 and OVERSAMPLE/2+1, which are 7, 8 and 9 by default. The count is 0 on the tick where the start edge is seen, and the bit value is the majority of the three samples. A single disturbed sample outside those counts has no effect.
- R3: Bits arrive least significant first. The layouts are as follows.
  - cfg_nine=0, no parity: the 8 bits go to rx_data[7:0] and rx_bit9 is 0.
  - cfg_nine=0 with parity: the 7 data bits go to rx_data[6:0] and the received parity bit goes to rx_data[7]. rx_bit9 is 0.
  - cfg_nine=1, no parity: the first 8 bits go to rx_data and the ninth bit goes to rx_bit9.
  - cfg_nine=1 with parity: the 8 data bits go to rx_data and the parity bit goes to rx_bit9.
- R4: rx_status bit 5 (ready) is set when a character is stored. rx_status bits 7, 6 and 4 always read 0.
- R5: rx_status bit 0 (parity) is set when parity is enabled and the received parity does not match. cfg_par_odd=1 selects odd parity; 0 selects even parity.
- R6: rx_status bit 1 (framing) is set when the voted stop bit is 0.
- R7: rx_status bit 2 (noise) is set when the three samples of any bit of the frame do not all agree. This covers the start bit, the payload bits and the stop bit.
- R8: rx_status bit 3 (overrun) is set when a character completes while ready is set. That new character is discarded, and the data, the ninth bit and the other flags keep their values.
- R9: A data read (rd_data) clears status bits 5, 3, 2, 1 and 0 only if a status read (rd_status) has happened since the last data read. A data read without that earlier status read changes nothing. Storing a new character cancels an earlier status read.
- R10: irq_rx equals ready AND ie_ready. irq_err is the OR of overrun, noise, framing and parity, each ANDed with its own enable. Both are registered and change on the same edge as the flags.
- R11: The receiver is ready for a new start edge right after the stop bit is evaluated, so back-to-back frames with no idle time are all received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversample tick, OVERSAMPLE ticks per bit |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| cfg_nine | input | 1 | 1 selects 9-bit frames, 0 selects 8-bit frames |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| rd_status | input | 1 | Single-cycle status read strobe |
| rd_data | input | 1 | Single-cycle data read strobe |
| ie_ready | input | 1 | Interrupt enable for the ready flag |
| ie_overrun | input | 1 | Interrupt enable for overrun |
| ie_noise | input | 1 | Interrupt enable for noise |
| ie_frame | input | 1 | Interrupt enable for framing error |
| ie_parity | input | 1 | Interrupt enable for parity error |
| rx_data | output | 8 | Received character |
| rx_bit9 | output | 1 | Ninth received bit (9-bit mode), otherwise 0 |
| rx_status | output | 8 | Flags: bit 5 ready, bit 3 overrun, bit 2 noise, bit 1 framing, bit 0 parity; bits 7, 6, 4 are 0 |
| irq_rx | output | 1 | Receive data interrupt request |
| irq_err | output | 1 | Receive error interrupt request |

## Verification
The bench builds the block with OVERSAMPLE=16 and SYNC_STAGES=2 and holds the tick high on every clock. With these values each bit lasts exactly 16 clocks. Counts 7, 8 and 9 fall on known clocks, so the bench can flip one sample inside the vote window and can also flip one outside it at count 3. The completion cycle of each frame is then a fixed sum of synchronizer depth, frame length and mid-bit offset. That lets the per-clock model place every flag change on an exact edge. It also lets the model line up reads and back-to-back frames precisely against frame completion.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  localparam int CHAR_W  = 8;
  localparam int PAY_MAX = CHAR_W + 1;
  localparam int IDX_W   = $clog2(PAY_MAX);

  // status byte bit positions
  localparam int FLG_RDY = 5;
  localparam int FLG_OVR = 3;
  localparam int FLG_NSE = 2;
  localparam int FLG_FRM = 1;
  localparam int FLG_PAR = 0;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              bit9;
    logic              perr;
    logic              ferr;
    logic              nerr;
  } rx_char_t;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_async,
  output logic rx_sync
);

  generate
    if (STAGES <= 1) begin : g_single
      logic stage_q;
      always_ff @(posedge clk) begin
        if (rst) stage_q <= 1'b1;
        else     stage_q <= rx_async;
      end
      assign rx_sync = stage_q;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-2:0], rx_async};
      end
      assign rx_sync = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/rx_vote_timer.sv
module rx_vote_timer #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic rx,
  input  logic launch,
  input  logic active,
  output logic bit_strobe,
  output logic bit_value,
  output logic bit_noisy
);

  localparam int CW  = $clog2(OSR);
  localparam int MID = OSR / 2;

  generate
    if (OSR < 4) begin : g_bad_osr
      $error("rx_vote_timer needs OSR of at least 4");
    end
  endgenerate

  logic [CW-1:0] cnt_q;
  logic          samp_a_q;
  logic          samp_b_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      samp_a_q <= 1'b1;
      samp_b_q <= 1'b1;
    end else if (launch) begin
      cnt_q <= CW'(1);
    end else if (active && tick) begin
      if (cnt_q == CW'(OSR - 1)) cnt_q <= '0;
      else                       cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(MID - 1)) samp_a_q <= rx;
      if (cnt_q == CW'(MID))     samp_b_q <= rx;
    end
  end

  assign bit_strobe = active && tick && (cnt_q == CW'(MID + 1));
  assign bit_value  = (samp_a_q & samp_b_q) | (samp_a_q & rx) | (samp_b_q & rx);
  assign bit_noisy  = (samp_a_q != samp_b_q) || (samp_b_q != rx);

  // R2
  strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
    bit_strobe |=> !bit_strobe);

endmodule

// File: rtl/rx_frame_ctl.sv
module rx_frame_ctl
  import serial_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     rx,
  input  logic     cfg_nine,
  input  logic     cfg_par_en,
  input  logic     cfg_par_odd,
  input  logic     bit_strobe,
  input  logic     bit_value,
  input  logic     bit_noisy,
  output logic     launch,
  output logic     active,
  output logic     char_valid,
  output rx_char_t char_out
);

  rx_state_e          st_q;
  logic [IDX_W-1:0]   idx_q;
  logic [PAY_MAX-1:0] pay_q;
  logic               noise_q;
  logic               nine_q;
  logic               pen_q;
  logic               odd_q;
  logic               done_q;
  rx_char_t           char_q;

  logic [IDX_W-1:0]   last_idx;
  logic [PAY_MAX-1:0] par_mask;

  assign last_idx = nine_q ? IDX_W'(PAY_MAX - 1) : IDX_W'(PAY_MAX - 2);
  assign par_mask = nine_q ? {PAY_MAX{1'b1}} : {1'b0, {(PAY_MAX-1){1'b1}}};
  assign launch   = (st_q == RX_IDLE) && tick && !rx;
  assign active   = (st_q != RX_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= RX_IDLE;
      idx_q   <= '0;
      pay_q   <= '0;
      noise_q <= 1'b0;
      nine_q  <= 1'b0;
      pen_q   <= 1'b0;
      odd_q   <= 1'b0;
      done_q  <= 1'b0;
      char_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        RX_IDLE: begin
          if (launch) begin
            st_q   <= RX_START;
            nine_q <= cfg_nine;
            pen_q  <= cfg_par_en;
            odd_q  <= cfg_par_odd;
          end
        end
        RX_START: begin
          if (bit_strobe) begin
            if (bit_value) begin
              st_q <= RX_IDLE;
            end else begin
              st_q    <= RX_DATA;
              idx_q   <= '0;
              noise_q <= bit_noisy;
            end
          end
        end
        RX_DATA: begin
          if (bit_strobe) begin
            pay_q[idx_q] <= bit_value;
            noise_q      <= noise_q | bit_noisy;
            if (idx_q == last_idx) st_q <= RX_STOP;
            else                   idx_q <= idx_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (bit_strobe) begin
            done_q      <= 1'b1;
            char_q.data <= pay_q[CHAR_W-1:0];
            char_q.bit9 <= nine_q & pay_q[PAY_MAX-1];
            char_q.perr <= pen_q & ((^(pay_q & par_mask)) ^ odd_q);
            char_q.ferr <= !bit_value;
            char_q.nerr <= noise_q | bit_noisy;
            st_q        <= RX_IDLE;
          end
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  assign char_valid = done_q;
  assign char_out   = char_q;

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R1
  false_start_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == RX_START && bit_strobe && bit_value) |=> (st_q == RX_IDLE && !done_q));

  // R11
  stop_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == RX_STOP && bit_strobe) |=> (st_q == RX_IDLE));

endmodule

// File: rtl/rx_flag_bank.sv
module rx_flag_bank
  import serial_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              char_valid,
  input  rx_char_t          char_in,
  input  logic              rd_status,
  input  logic              rd_data,
  input  logic              ie_ready,
  input  logic              ie_overrun,
  input  logic              ie_noise,
  input  logic              ie_frame,
  input  logic              ie_parity,
  output logic [CHAR_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic [7:0]        rx_status,
  output logic              irq_rx,
  output logic              irq_err
);

  logic [CHAR_W-1:0] data_q, data_n;
  logic              b9_q, b9_n;
  logic              rdy_q, rdy_n;
  logic              ovr_q, ovr_n;
  logic              nse_q, nse_n;
  logic              frm_q, frm_n;
  logic              par_q, par_n;
  logic              armed_q, armed_n;
  logic              irq_rx_q, irq_err_q;
  logic              clr;

  always_comb begin
    clr     = rd_data && armed_q;
    data_n  = data_q;
    b9_n    = b9_q;
    rdy_n   = rdy_q;
    ovr_n   = ovr_q;
    nse_n   = nse_q;
    frm_n   = frm_q;
    par_n   = par_q;
    armed_n = armed_q;
    if (clr) begin
      rdy_n   = 1'b0;
      ovr_n   = 1'b0;
      nse_n   = 1'b0;
      frm_n   = 1'b0;
      par_n   = 1'b0;
      armed_n = 1'b0;
    end
    if (rd_status) armed_n = 1'b1;
    if (char_valid) begin
      if (rdy_q && !clr) begin
        ovr_n = 1'b1;
      end else begin
        data_n  = char_in.data;
        b9_n    = char_in.bit9;
        rdy_n   = 1'b1;
        nse_n   = char_in.nerr;
        frm_n   = char_in.ferr;
        par_n   = char_in.perr;
        armed_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q    <= '0;
      b9_q      <= 1'b0;
      rdy_q     <= 1'b0;
      ovr_q     <= 1'b0;
      nse_q     <= 1'b0;
      frm_q     <= 1'b0;
      par_q     <= 1'b0;
      armed_q   <= 1'b0;
      irq_rx_q  <= 1'b0;
      irq_err_q <= 1'b0;
    end else begin
      data_q    <= data_n;
      b9_q      <= b9_n;
      rdy_q     <= rdy_n;
      ovr_q     <= ovr_n;
      nse_q     <= nse_n;
      frm_q     <= frm_n;
      par_q     <= par_n;
      armed_q   <= armed_n;
      irq_rx_q  <= rdy_n & ie_ready;
      irq_err_q <= (ovr_n & ie_overrun) | (nse_n & ie_noise) |
                   (frm_n & ie_frame) | (par_n & ie_parity);
    end
  end

  always_comb begin
    rx_status          = '0;
    rx_status[FLG_RDY] = rdy_q;
    rx_status[FLG_OVR] = ovr_q;
    rx_status[FLG_NSE] = nse_q;
    rx_status[FLG_FRM] = frm_q;
    rx_status[FLG_PAR] = par_q;
  end

  assign rx_data = data_q;
  assign rx_bit9 = b9_q;
  assign irq_rx  = irq_rx_q;
  assign irq_err = irq_err_q;

  // R8
  ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
    (char_valid && rdy_q && !clr) |=> ovr_q);

  // R8
  ovr_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (char_valid && rdy_q && !clr) |=> ($stable(data_q) && $stable(b9_q) && $stable(par_q)));

  // R9
  lone_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data && !armed_q && !char_valid) |=> $stable(rdy_q));

  // R9
  clear_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data && armed_q && !char_valid) |=> (!rdy_q && !ovr_q && !nse_q && !frm_q && !par_q));

  // R10
  irq_err_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq_err |-> (ovr_q || nse_q || frm_q || par_q));

  // R10
  irq_rx_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq_rx |-> rdy_q);

endmodule

// File: rtl/serial_rx_framer.sv
module serial_rx_framer
  import serial_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       os_tick,
  input  logic       rx_in,
  input  logic       cfg_nine,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       rd_status,
  input  logic       rd_data,
  input  logic       ie_ready,
  input  logic       ie_overrun,
  input  logic       ie_noise,
  input  logic       ie_frame,
  input  logic       ie_parity,
  output logic [7:0] rx_data,
  output logic       rx_bit9,
  output logic [7:0] rx_status,
  output logic       irq_rx,
  output logic       irq_err
);

  logic     rx_s;
  logic     launch;
  logic     active;
  logic     bit_strobe;
  logic     bit_value;
  logic     bit_noisy;
  logic     char_valid;
  rx_char_t char_w;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .rx_async (rx_in),
    .rx_sync  (rx_s)
  );

  rx_vote_timer #(.OSR(OVERSAMPLE)) u_vote (
    .clk        (clk),
    .rst        (rst),
    .tick       (os_tick),
    .rx         (rx_s),
    .launch     (launch),
    .active     (active),
    .bit_strobe (bit_strobe),
    .bit_value  (bit_value),
    .bit_noisy  (bit_noisy)
  );

  rx_frame_ctl u_frame (
    .clk         (clk),
    .rst         (rst),
    .tick        (os_tick),
    .rx          (rx_s),
    .cfg_nine    (cfg_nine),
    .cfg_par_en  (cfg_par_en),
    .cfg_par_odd (cfg_par_odd),
    .bit_strobe  (bit_strobe),
    .bit_value   (bit_value),
    .bit_noisy   (bit_noisy),
    .launch      (launch),
    .active      (active),
    .char_valid  (char_valid),
    .char_out    (char_w)
  );

  rx_flag_bank u_flags (
    .clk        (clk),
    .rst        (rst),
    .char_valid (char_valid),
    .char_in    (char_w),
    .rd_status  (rd_status),
    .rd_data    (rd_data),
    .ie_ready   (ie_ready),
    .ie_overrun (ie_overrun),
    .ie_noise   (ie_noise),
    .ie_frame   (ie_frame),
    .ie_parity  (ie_parity),
    .rx_data    (rx_data),
    .rx_bit9    (rx_bit9),
    .rx_status  (rx_status),
    .irq_rx     (irq_rx),
    .irq_err    (irq_err)
  );

endmodule

// File: tb/test_serial_rx_framer.sv
module test_serial_rx_framer;

  localparam int OSR  = 16;
  localparam int SYNC = 2;
  localparam int MID  = OSR / 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       os_tick = 1'b1;
  logic       rx_in = 1'b1;
  logic       cfg_nine = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic       rd_status = 1'b0, rd_data = 1'b0;
  logic       ie_ready = 1'b0, ie_overrun = 1'b0, ie_noise = 1'b0;
  logic       ie_frame = 1'b0, ie_parity = 1'b0;
  logic [7:0] rx_data;
  logic       rx_bit9;
  logic [7:0] rx_status;
  logic       irq_rx, irq_err;

  always #2 clk = ~clk;

  serial_rx_framer #(.OVERSAMPLE(OSR), .SYNC_STAGES(SYNC)) i_serial_rx_framer (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rx_in(rx_in),
    .cfg_nine(cfg_nine), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .rd_status(rd_status), .rd_data(rd_data),
    .ie_ready(ie_ready), .ie_overrun(ie_overrun), .ie_noise(ie_noise),
    .ie_frame(ie_frame), .ie_parity(ie_parity),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_status(rx_status),
    .irq_rx(irq_rx), .irq_err(irq_err)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done_flag = 0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int         due;
    logic [7:0] d;
    logic       b9, pe, fe, ne;
  } ev_t;
  ev_t evq[$];

  logic [7:0] m_data;
  logic m_b9, m_rdy, m_ovr, m_nse, m_frm, m_par, m_armed;

  task automatic cmp(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  // per-clock reference model and comparison
  always @(posedge clk) begin
    logic clr_m;
    ev_t  ev;
    #1;
    if (rst) begin
      m_data = 8'h00; m_b9 = 0; m_rdy = 0; m_ovr = 0;
      m_nse = 0; m_frm = 0; m_par = 0; m_armed = 0;
    end else begin
      logic rdy_old;
      rdy_old = m_rdy;
      clr_m   = rd_data && m_armed;
      if (clr_m) begin
        m_rdy = 0; m_ovr = 0; m_nse = 0; m_frm = 0; m_par = 0; m_armed = 0;
      end
      if (rd_status) m_armed = 1;
      if (evq.size() > 0 && evq[0].due == cyc) begin
        ev = evq.pop_front();
        if (rdy_old && !clr_m) begin
          m_ovr = 1;
        end else begin
          m_data = ev.d; m_b9 = ev.b9; m_rdy = 1;
          m_par = ev.pe; m_frm = ev.fe; m_nse = ev.ne; m_armed = 0;
        end
      end
    end
    if (!done_flag) begin
      cmp("R3 data", rx_data, m_data);
      cmp("R3 ninth bit", rx_bit9, m_b9);
      cmp("R4 ready", rx_status[5], m_rdy);
      cmp("R4 unused bits", {rx_status[7:6], rx_status[4]}, 0);
      cmp("R5 parity flag", rx_status[0], m_par);
      cmp("R6 framing flag", rx_status[1], m_frm);
      cmp("R7 noise flag", rx_status[2], m_nse);
      cmp("R8 overrun flag", rx_status[3], m_ovr);
      cmp("R10 irq_rx", irq_rx, m_rdy & ie_ready);
      cmp("R10 irq_err", irq_err, (m_ovr & ie_overrun) | (m_nse & ie_noise) |
                                  (m_frm & ie_frame) | (m_par & ie_parity));
    end
  end

  // gbit: bit index to disturb (-1 none), gpos: oversample count to disturb
  task automatic send_frame(input logic [8:0] d, input logic bad_par,
                            input logic stop_v, input int gbit, input int gpos,
                            input int gap);
    logic [8:0] pay;
    logic [10:0] seq;
    logic pb, e_b9, e_pe, e_ne;
    logic [7:0] e_d;
    int L, S, k;
    ev_t ev;
    pay = '0; e_b9 = 0; e_pe = 0;
    if (!cfg_nine && !cfg_par_en) begin
      L = 8; pay[7:0] = d[7:0]; e_d = d[7:0];
    end else if (!cfg_nine) begin
      L = 8; pb = (^d[6:0]) ^ cfg_par_odd ^ bad_par;
      pay[7:0] = {pb, d[6:0]}; e_d = {pb, d[6:0]}; e_pe = bad_par;
    end else if (!cfg_par_en) begin
      L = 9; pay = d; e_d = d[7:0]; e_b9 = d[8];
    end else begin
      L = 9; pb = (^d[7:0]) ^ cfg_par_odd ^ bad_par;
      pay = {pb, d[7:0]}; e_d = d[7:0]; e_b9 = pb; e_pe = bad_par;
    end
    S = L + 1;
    seq = '1;
    seq[0] = 1'b0;
    for (int i = 0; i < L; i++) seq[i+1] = pay[i];
    seq[S] = stop_v;
    e_ne = (gbit >= 0) && (gpos >= MID - 1) && (gpos <= MID + 1);
    k = 0;
    for (int b = 0; b <= S; b++) begin
      for (int c = 0; c < OSR; c++) begin
        @(negedge clk);
        if (b == 0 && c == 0) begin
          k = cyc;
          ev.due = k + SYNC + S * OSR + MID + 3;
          ev.d = e_d; ev.b9 = e_b9; ev.pe = e_pe; ev.fe = !stop_v; ev.ne = e_ne;
          evq.push_back(ev);
        end
        rx_in = ((b == gbit) && (c == gpos)) ? ~seq[b] : seq[b];
      end
    end
    if (gap > 0) begin
      @(negedge clk);
      rx_in = 1'b1;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic read_status();
    @(negedge clk); rd_status = 1'b1;
    @(negedge clk); rd_status = 1'b0;
  endtask

  task automatic read_data();
    @(negedge clk); rd_data = 1'b1;
    @(negedge clk); rd_data = 1'b0;
  endtask

  task automatic clear_all();
    read_status();
    read_data();
  endtask

  task automatic set_cfg(input logic nine, input logic pen, input logic odd);
    @(negedge clk);
    cfg_nine = nine; cfg_par_en = pen; cfg_par_odd = odd;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired (all requirements)");
    done_flag = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  localparam int GAP = 3 * OSR;

  initial begin
    repeat (4) @(negedge clk);
    cmp("R4 reset ready clear", rx_status, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // 8-bit, no parity
    set_cfg(0, 0, 0);
    send_frame(9'h0A5, 0, 1, -1, 0, GAP);
    cmp("R3 8-bit data", rx_data, 8'hA5);
    read_data();
    cmp("R9 lone data read keeps ready", rx_status[5], 1);
    clear_all();
    cmp("R9 status then data clears", rx_status, 0);

    ie_ready = 1; ie_overrun = 1; ie_noise = 1; ie_frame = 1; ie_parity = 1;

    // 8-bit with even and odd parity
    set_cfg(0, 1, 0);
    send_frame(9'h03C, 0, 1, -1, 0, GAP);
    cmp("R3 parity in top data bit", rx_data, {^7'h3C, 7'h3C});
    clear_all();
    send_frame(9'h055, 1, 1, -1, 0, GAP);
    cmp("R5 even parity error", rx_status[0], 1);
    cmp("R10 irq_err on parity", irq_err, 1);
    clear_all();
    set_cfg(0, 1, 1);
    send_frame(9'h012, 0, 1, -1, 0, GAP);
    cmp("R5 odd parity good", rx_status[0], 0);
    clear_all();
    send_frame(9'h07F, 1, 1, -1, 0, GAP);
    cmp("R5 odd parity error", rx_status[0], 1);
    clear_all();

    // 9-bit formats
    set_cfg(1, 0, 0);
    send_frame(9'h15A, 0, 1, -1, 0, GAP);
    cmp("R3 ninth bit", rx_bit9, 1);
    clear_all();
    set_cfg(1, 1, 0);
    send_frame(9'h0C3, 0, 1, -1, 0, GAP);
    cmp("R3 9-bit parity bit in ninth", rx_bit9, ^8'hC3);
    clear_all();
    set_cfg(1, 1, 1);
    send_frame(9'h081, 1, 1, -1, 0, GAP);
    cmp("R5 9-bit odd parity error", rx_status[0], 1);
    clear_all();

    // sampling and noise
    ie_noise = 0;
    set_cfg(0, 0, 0);
    send_frame(9'h0B4, 0, 1, 4, MID, GAP);
    cmp("R2 majority rejects one bad sample", rx_data, 8'hB4);
    cmp("R7 noise flag on data bit", rx_status[2], 1);
    clear_all();
    ie_noise = 1;
    send_frame(9'h033, 0, 1, 0, MID - 1, GAP);
    cmp("R7 noise on start bit", rx_status[2], 1);
    clear_all();
    send_frame(9'h0E7, 0, 1, 9, MID + 1, GAP);
    cmp("R7 noise on stop bit", rx_status[2], 1);
    clear_all();
    send_frame(9'h0E7, 0, 1, 2, 3, GAP);
    cmp("R2 disturbance outside window ignored", rx_status[2], 0);
    clear_all();

    // framing
    send_frame(9'h066, 0, 0, -1, 0, GAP);
    cmp("R6 framing error", rx_status[1], 1);
    clear_all();

    // overrun
    ie_ready = 0;
    send_frame(9'h011, 0, 1, -1, 0, GAP);
    send_frame(9'h022, 1, 0, -1, 0, GAP);
    cmp("R8 overrun flag", rx_status[3], 1);
    cmp("R8 discarded char keeps data", rx_data, 8'h11);
    cmp("R8 discarded char keeps framing", rx_status[1], 0);
    clear_all();
    cmp("R9 clear removes overrun", rx_status, 0);
    ie_ready = 1;

    // stale status read cancelled by new character
    read_status();
    send_frame(9'h044, 0, 1, -1, 0, GAP);
    read_data();
    cmp("R9 new char cancels earlier status read", rx_status[5], 1);
    clear_all();

    // rejected start
    @(negedge clk); rx_in = 1'b0;
    repeat (3) @(negedge clk);
    rx_in = 1'b1;
    repeat (GAP) @(negedge clk);
    cmp("R1 short low pulse gives no char", rx_status[5], 0);

    // back-to-back frames
    send_frame(9'h0A0, 0, 1, -1, 0, 0);
    send_frame(9'h05F, 0, 1, -1, 0, GAP);
    cmp("R11 second back-to-back frame seen", rx_status[3], 1);
    cmp("R11 first frame data kept", rx_data, 8'hA0);
    clear_all();

    repeat (8) @(negedge clk);
    cmp("R4 idle after all", rx_status, 0);
    done_flag = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule